// File: doc/BRIEF.md
# Segmented Issue Queue Wakeup Array

This block holds the operand-readiness state of a non-compacting out-of-order issue queue. The queue is split into equal segments. Each entry keeps two source tags, a ready flag for each of them and a valid bit. An entry raises its request line once it is valid and both of its flags are set. Choosing among the requesting entries is left to a separate select stage, and the instruction payload is held elsewhere.

Each completion port delivers the destination tag of a finishing result together with information the producer recorded at dispatch. That information is a direct pointer to one consumer operand, a valid bit for the pointer, and two hint bits. The first hint (near) says a consumer sits in segment 0. The second hint (far) says further consumers sit beyond segment 0.

A tag that must be broadcast is compared against segment 0 at once. It then travels down a register pipeline that reaches one more segment per cycle. In the same cycle as the segment-0 compare, the pointer sets the ready flag of its consumer directly, whatever segment that consumer is in. Broadcasts are gated by the hints, so most tags are never compared anywhere past segment 0. Two running counters report how many segment broadcasts and tag comparisons took place.

Top module: `seg_iq_wakeup`

## Requirements
- R1: After a synchronous reset, every entry is invalid and every ready flag and request line is 0. Both activity counters read 0.
- R2: An allocation writes the entry's two tags and initial ready flags and marks the entry valid. When an allocation and a free name the same entry in the same cycle, the allocation wins. Wakeups aimed at the entry in that cycle are discarded. A ready flag is cleared only by an allocation of its entry.
- R3: A free clears the entry's valid bit, so its request line drops at the next edge. Wakeups, by broadcast or by pointer, do not change the flags of an entry that is not valid.
- R4: Request line i is high exactly when entry i is valid and both of its ready flags are set.
- R5: A completion with the near hint or the far hint set compares its tag with both operands of every entry in segment 0. Matching flags are set on the same clock edge that samples the completion.
- R6: A completion with the far hint set reaches segment k (k ≥ 1) k cycles after the edge that samples it. Matching operands there are set on that later edge.
- R7: A completion with only the near hint set never sets a flag in a segment other than segment 0.
- R8: A completion with neither hint set performs no broadcast and no comparison. The counters do not move for it.
- R9: When a completion's pointer-valid bit is set, the pointer field is decoded. Its low IDX_W bits give the entry and its top bit gives the operand: 0 selects operand 0 and 1 selects operand 1. Only that flag is set, on the same edge as a segment-0 broadcast, for an entry in any segment.
- R10: All IW completion ports act in the same cycle, and new tags enter the broadcast pipeline every cycle without stalling. The broadcast count rises by at most SEGS×IW per cycle.
- R11: Each segment compare performed by one port adds 1 to the broadcast counter and 2×SEG_SZ to the comparison counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_en | input | 1 | Write an entry this cycle |
| alloc_idx | input | IDX_W | Entry to write |
| alloc_tag0 | input | TAG_W | Source tag of operand 0 |
| alloc_tag1 | input | TAG_W | Source tag of operand 1 |
| alloc_rdy0 | input | 1 | Operand 0 already available |
| alloc_rdy1 | input | 1 | Operand 1 already available |
| free_en | input | 1 | Release an entry this cycle |
| free_idx | input | IDX_W | Entry to release |
| done_vld | input | IW | Per-port completion valid |
| done_tag | input | IW×TAG_W | Per-port result tag, port p at bits p×TAG_W |
| done_civ | input | IW | Per-port consumer pointer valid |
| done_cii | input | IW×(IDX_W+1) | Per-port consumer pointer {operand, entry} |
| done_fc | input | IW | Per-port near hint |
| done_hr | input | IW | Per-port far hint |
| rdy0 | output | N | Operand 0 ready flags |
| rdy1 | output | N | Operand 1 ready flags |
| req | output | N | Request vector to select |
| bcast_cnt | output | CNT_W | Segment broadcasts performed |
| cmp_cnt | output | CNT_W | Tag comparisons performed |

## Verification
Several properties are checked on every cycle. A ready flag never falls except on an allocation of its entry. A request never stands without both flags. A free removes the request at the next edge. The comparison counter always moves in step with the broadcast counter. After enough cycles with no hinted completion, the broadcast counter stays still.

Other behaviour needs the bench's scenarios to show it. This covers the segment-by-segment arrival time of a far-hinted tag and the absence of far-segment wakeups for a near-only tag. It also covers operand selection by the pointer, concurrent ports, and the allocation-over-free priority. The bench checks these against a cycle model it runs alongside long random traffic.

// File: rtl/iq_pkg.sv
package iq_pkg;

    // Operand selected by the top bit of a consumer pointer
    typedef enum logic {
        OPA = 1'b0,
        OPB = 1'b1
    } opsel_e;

    // Whether a completion's tag is compared in segment seg
    function automatic logic seg_gate(input logic fc, input logic hr, input int unsigned seg);
        return (seg == 0) ? (fc | hr) : hr;
    endfunction

endpackage

// File: rtl/iq_bcast_pipe.sv
module iq_bcast_pipe
    import iq_pkg::*;
#(
    parameter int SEGS  = 8,
    parameter int IW    = 8,
    parameter int TAG_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [IW-1:0]                        in_vld,
    input  logic [IW-1:0][TAG_W-1:0]             in_tag,
    input  logic [IW-1:0]                        in_fc,
    input  logic [IW-1:0]                        in_hr,
    output logic [SEGS-1:0][IW-1:0]              seg_vld,
    output logic [SEGS-1:0][IW-1:0][TAG_W-1:0]   seg_tag
);

    // Segment 0 sees the completion bus directly
    always_comb begin
        for (int p = 0; p < IW; p++) begin
            seg_vld[0][p] = in_vld[p] & seg_gate(in_fc[p], in_hr[p], 0);
        end
        seg_tag[0] = in_tag;
    end

    // One register stage per further segment
    for (genvar s = 1; s < SEGS; s++) begin : g_stage
        logic [IW-1:0]            v_r;
        logic [IW-1:0][TAG_W-1:0] t_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                v_r <= '0;
                t_r <= '0;
            end else begin
                for (int p = 0; p < IW; p++) begin
                    v_r[p] <= (s == 1) ? (in_vld[p] & seg_gate(in_fc[p], in_hr[p], s))
                                       : seg_vld[s-1][p];
                end
                t_r <= (s == 1) ? in_tag : seg_tag[s-1];
            end
        end

        assign seg_vld[s] = v_r;
        assign seg_tag[s] = t_r;
    end

endmodule

// File: rtl/iq_segment.sv
module iq_segment #(
    parameter int SEG_SZ = 16,
    parameter int IW     = 8,
    parameter int TAG_W  = 8
) (
    input  logic [IW-1:0]                bc_vld,
    input  logic [IW-1:0][TAG_W-1:0]     bc_tag,
    input  logic [SEG_SZ-1:0][TAG_W-1:0] ent_tag0,
    input  logic [SEG_SZ-1:0][TAG_W-1:0] ent_tag1,
    output logic [SEG_SZ-1:0]            hit0,
    output logic [SEG_SZ-1:0]            hit1
);

    // Per-entry OR over all broadcasting ports
    always_comb begin
        hit0 = '0;
        hit1 = '0;
        for (int e = 0; e < SEG_SZ; e++) begin
            for (int p = 0; p < IW; p++) begin
                if (bc_vld[p] && bc_tag[p] == ent_tag0[e]) hit0[e] = 1'b1;
                if (bc_vld[p] && bc_tag[p] == ent_tag1[e]) hit1[e] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/iq_index_dec.sv
module iq_index_dec
    import iq_pkg::*;
#(
    parameter int N     = 128,
    parameter int IW    = 8,
    parameter int IDX_W = 7
) (
    input  logic [IW-1:0]            vld,
    input  logic [IW-1:0]            civ,
    input  logic [IW-1:0][IDX_W:0]   cii,
    output logic [N-1:0]             wake0,
    output logic [N-1:0]             wake1
);

    // One decoder per port, outputs ORed per operand flag
    always_comb begin
        int unsigned ix;
        wake0 = '0;
        wake1 = '0;
        for (int p = 0; p < IW; p++) begin
            ix = int'(cii[p][IDX_W-1:0]);
            if (vld[p] && civ[p] && ix < N) begin
                if (opsel_e'(cii[p][IDX_W]) == OPB) wake1[ix] = 1'b1;
                else                                wake0[ix] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/seg_iq_wakeup.sv
module seg_iq_wakeup #(
    parameter int SEGS   = 8,
    parameter int SEG_SZ = 16,
    parameter int IW     = 8,
    parameter int TAG_W  = 8,
    parameter int CNT_W  = 32
) (
    input  logic                                        clk,
    input  logic                                        rst,
    input  logic                                        alloc_en,
    input  logic [$clog2(SEGS*SEG_SZ)-1:0]              alloc_idx,
    input  logic [TAG_W-1:0]                            alloc_tag0,
    input  logic [TAG_W-1:0]                            alloc_tag1,
    input  logic                                        alloc_rdy0,
    input  logic                                        alloc_rdy1,
    input  logic                                        free_en,
    input  logic [$clog2(SEGS*SEG_SZ)-1:0]              free_idx,
    input  logic [IW-1:0]                               done_vld,
    input  logic [IW*TAG_W-1:0]                         done_tag,
    input  logic [IW-1:0]                               done_civ,
    input  logic [IW*($clog2(SEGS*SEG_SZ)+1)-1:0]       done_cii,
    input  logic [IW-1:0]                               done_fc,
    input  logic [IW-1:0]                               done_hr,
    output logic [SEGS*SEG_SZ-1:0]                      rdy0,
    output logic [SEGS*SEG_SZ-1:0]                      rdy1,
    output logic [SEGS*SEG_SZ-1:0]                      req,
    output logic [CNT_W-1:0]                            bcast_cnt,
    output logic [CNT_W-1:0]                            cmp_cnt
);

    localparam int N     = SEGS * SEG_SZ;
    localparam int IDX_W = $clog2(N);
    localparam int NB_W  = $clog2(SEGS * IW + 1);

    logic [IW-1:0][TAG_W-1:0]           tag_a;
    logic [IW-1:0][IDX_W:0]             cii_a;
    logic [SEGS-1:0][IW-1:0]            seg_vld;
    logic [SEGS-1:0][IW-1:0][TAG_W-1:0] seg_tag;

    logic [N-1:0]            vld_q, r0_q, r1_q;
    logic [N-1:0][TAG_W-1:0] t0_q, t1_q;
    logic [N-1:0]            cam0, cam1, ix0, ix1;
    logic [N-1:0]            vld_n, r0_n, r1_n;
    logic [N-1:0][TAG_W-1:0] t0_n, t1_n;
    logic [NB_W-1:0]         nb;

    assign tag_a = done_tag;
    assign cii_a = done_cii;

    iq_bcast_pipe #(.SEGS(SEGS), .IW(IW), .TAG_W(TAG_W)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (done_vld),
        .in_tag  (tag_a),
        .in_fc   (done_fc),
        .in_hr   (done_hr),
        .seg_vld (seg_vld),
        .seg_tag (seg_tag)
    );

    for (genvar s = 0; s < SEGS; s++) begin : g_seg
        iq_segment #(.SEG_SZ(SEG_SZ), .IW(IW), .TAG_W(TAG_W)) u_seg (
            .bc_vld   (seg_vld[s]),
            .bc_tag   (seg_tag[s]),
            .ent_tag0 (t0_q[s*SEG_SZ +: SEG_SZ]),
            .ent_tag1 (t1_q[s*SEG_SZ +: SEG_SZ]),
            .hit0     (cam0[s*SEG_SZ +: SEG_SZ]),
            .hit1     (cam1[s*SEG_SZ +: SEG_SZ])
        );
    end

    iq_index_dec #(.N(N), .IW(IW), .IDX_W(IDX_W)) u_idx (
        .vld   (done_vld),
        .civ   (done_civ),
        .cii   (cii_a),
        .wake0 (ix0),
        .wake1 (ix1)
    );

    // Next entry state: wakeups on valid entries, then free, then allocation
    always_comb begin
        r0_n  = r0_q | (vld_q & (cam0 | ix0));
        r1_n  = r1_q | (vld_q & (cam1 | ix1));
        vld_n = vld_q;
        t0_n  = t0_q;
        t1_n  = t1_q;
        if (free_en) vld_n[free_idx] = 1'b0;
        if (alloc_en) begin
            vld_n[alloc_idx] = 1'b1;
            r0_n[alloc_idx]  = alloc_rdy0;
            r1_n[alloc_idx]  = alloc_rdy1;
            t0_n[alloc_idx]  = alloc_tag0;
            t1_n[alloc_idx]  = alloc_tag1;
        end
    end

    always_comb begin
        nb = '0;
        for (int s = 0; s < SEGS; s++) begin
            for (int p = 0; p < IW; p++) begin
                nb = nb + NB_W'(seg_vld[s][p]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q     <= '0;
            r0_q      <= '0;
            r1_q      <= '0;
            t0_q      <= '0;
            t1_q      <= '0;
            bcast_cnt <= '0;
            cmp_cnt   <= '0;
        end else begin
            vld_q     <= vld_n;
            r0_q      <= r0_n;
            r1_q      <= r1_n;
            t0_q      <= t0_n;
            t1_q      <= t1_n;
            bcast_cnt <= bcast_cnt + CNT_W'(nb);
            cmp_cnt   <= cmp_cnt + CNT_W'(nb) * CNT_W'(2 * SEG_SZ);
        end
    end

    assign rdy0 = r0_q;
    assign rdy1 = r1_q;
    assign req  = vld_q & r0_q & r1_q;

endmodule

// File: rtl/seg_iq_wakeup_chk.sv
module seg_iq_wakeup_chk #(
    parameter int SEGS   = 8,
    parameter int SEG_SZ = 16,
    parameter int IW     = 8,
    parameter int CNT_W  = 32
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             alloc_en,
    input logic [$clog2(SEGS*SEG_SZ)-1:0]   alloc_idx,
    input logic                             free_en,
    input logic [$clog2(SEGS*SEG_SZ)-1:0]   free_idx,
    input logic [IW-1:0]                    done_vld,
    input logic [IW-1:0]                    done_fc,
    input logic [IW-1:0]                    done_hr,
    input logic [SEGS*SEG_SZ-1:0]           rdy0,
    input logic [SEGS*SEG_SZ-1:0]           rdy1,
    input logic [SEGS*SEG_SZ-1:0]           req,
    input logic [CNT_W-1:0]                 bcast_cnt,
    input logic [CNT_W-1:0]                 cmp_cnt
);

    localparam int N   = SEGS * SEG_SZ;
    localparam int Q_W = $clog2(SEGS + 1);

    logic [N-1:0]     amask;
    logic [CNT_W-1:0] prev_b, prev_c, db, dc;
    logic [Q_W-1:0]   quiet_q;
    logic             cnd_q;

    assign amask = alloc_en ? (N'(1) << alloc_idx) : '0;
    assign db    = bcast_cnt - prev_b;
    assign dc    = cmp_cnt - prev_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_b  <= '0;
            prev_c  <= '0;
            quiet_q <= Q_W'(SEGS);
            cnd_q   <= 1'b0;
        end else begin
            prev_b  <= bcast_cnt;
            prev_c  <= cmp_cnt;
            if (|(done_vld & done_hr))       quiet_q <= '0;
            else if (quiet_q != Q_W'(SEGS))  quiet_q <= quiet_q + 1'b1;
            cnd_q   <= !(|(done_vld & (done_fc | done_hr))) && (quiet_q >= Q_W'(SEGS - 1));
        end
    end

    // R2: a ready flag falls only when its entry is reallocated
    p_rdy_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        ((~rdy0 & $past(rdy0) & ~$past(amask)) == '0) &&
        ((~rdy1 & $past(rdy1) & ~$past(amask)) == '0));

    // R3: a free that is not overridden removes the request
    p_free_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (free_en && !(alloc_en && alloc_idx == free_idx)) |=> !req[$past(free_idx)]);

    // R4: no request without both operands ready
    p_req_rdy_r4: assert property (@(posedge clk) disable iff (rst)
        (req & ~(rdy0 & rdy1)) == '0);

    // R8: no hinted traffic in flight means no broadcast activity
    p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        cnd_q |-> (db == '0));

    // R10: bounded broadcasts per cycle
    p_bcast_bound_r10: assert property (@(posedge clk) disable iff (rst)
        db <= CNT_W'(SEGS * IW));

    // R11: comparisons follow broadcasts
    p_cmp_ratio_r11: assert property (@(posedge clk) disable iff (rst)
        dc == db * CNT_W'(2 * SEG_SZ));

endmodule

bind seg_iq_wakeup seg_iq_wakeup_chk #(
    .SEGS(SEGS), .SEG_SZ(SEG_SZ), .IW(IW), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .alloc_en  (alloc_en),
    .alloc_idx (alloc_idx),
    .free_en   (free_en),
    .free_idx  (free_idx),
    .done_vld  (done_vld),
    .done_fc   (done_fc),
    .done_hr   (done_hr),
    .rdy0      (rdy0),
    .rdy1      (rdy1),
    .req       (req),
    .bcast_cnt (bcast_cnt),
    .cmp_cnt   (cmp_cnt)
);

// File: tb/sim_seg_iq_wakeup.sv
module sim_seg_iq_wakeup;

    localparam int SEGS   = 4;
    localparam int SEG_SZ = 4;
    localparam int IW     = 2;
    localparam int TAG_W  = 6;
    localparam int CNT_W  = 32;
    localparam int N      = SEGS * SEG_SZ;
    localparam int IDX_W  = $clog2(N);
    localparam int CII_W  = IDX_W + 1;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  alloc_en = 1'b0;
    logic [IDX_W-1:0]      alloc_idx = '0;
    logic [TAG_W-1:0]      alloc_tag0 = '0, alloc_tag1 = '0;
    logic                  alloc_rdy0 = 1'b0, alloc_rdy1 = 1'b0;
    logic                  free_en = 1'b0;
    logic [IDX_W-1:0]      free_idx = '0;
    logic [IW-1:0]         done_vld = '0, done_civ = '0, done_fc = '0, done_hr = '0;
    logic [IW*TAG_W-1:0]   done_tag = '0;
    logic [IW*CII_W-1:0]   done_cii = '0;
    logic [N-1:0]          rdy0, rdy1, req;
    logic [CNT_W-1:0]      bcast_cnt, cmp_cnt;

    int total = 0;
    int bad   = 0;

    // Reference model state
    logic [N-1:0] m_v = '0, m_r0 = '0, m_r1 = '0;
    int           m_t0 [N];
    int           m_t1 [N];
    bit           m_pv [SEGS][IW];
    int           m_pt [SEGS][IW];
    longint       m_bc = 0, m_cmp = 0;

    always #5 clk = ~clk;

    seg_iq_wakeup #(.SEGS(SEGS), .SEG_SZ(SEG_SZ), .IW(IW), .TAG_W(TAG_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst),
        .alloc_en(alloc_en), .alloc_idx(alloc_idx), .alloc_tag0(alloc_tag0), .alloc_tag1(alloc_tag1),
        .alloc_rdy0(alloc_rdy0), .alloc_rdy1(alloc_rdy1),
        .free_en(free_en), .free_idx(free_idx),
        .done_vld(done_vld), .done_tag(done_tag), .done_civ(done_civ), .done_cii(done_cii),
        .done_fc(done_fc), .done_hr(done_hr),
        .rdy0(rdy0), .rdy1(rdy1), .req(req), .bcast_cnt(bcast_cnt), .cmp_cnt(cmp_cnt)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int seg_of(input int e);
        return e / SEG_SZ;
    endfunction

    // Model of one clock edge, from the requirements
    task automatic model_edge();
        logic [N-1:0] s0, s1, nv;
        bit           npv [SEGS][IW];
        int           npt [SEGS][IW];
        int           nb = 0;
        s0 = '0; s1 = '0;
        for (int p = 0; p < IW; p++) begin
            int tg = int'(done_tag[p*TAG_W +: TAG_W]);
            if (done_vld[p] && (done_fc[p] || done_hr[p])) begin
                nb++;
                for (int e = 0; e < SEG_SZ; e++) begin
                    if (m_t0[e] == tg) s0[e] = 1'b1;
                    if (m_t1[e] == tg) s1[e] = 1'b1;
                end
            end
            if (done_vld[p] && done_civ[p]) begin
                int ix = int'(done_cii[p*CII_W +: IDX_W]);
                if (done_cii[p*CII_W + IDX_W]) s1[ix] = 1'b1;
                else                           s0[ix] = 1'b1;
            end
        end
        for (int s = 1; s < SEGS; s++) begin
            for (int p = 0; p < IW; p++) begin
                if (m_pv[s][p]) begin
                    nb++;
                    for (int e = s*SEG_SZ; e < (s+1)*SEG_SZ; e++) begin
                        if (m_t0[e] == m_pt[s][p]) s0[e] = 1'b1;
                        if (m_t1[e] == m_pt[s][p]) s1[e] = 1'b1;
                    end
                end
            end
        end
        for (int p = 0; p < IW; p++) begin
            npv[1][p] = done_vld[p] && done_hr[p];
            npt[1][p] = int'(done_tag[p*TAG_W +: TAG_W]);
            for (int s = 2; s < SEGS; s++) begin
                npv[s][p] = m_pv[s-1][p];
                npt[s][p] = m_pt[s-1][p];
            end
        end
        for (int s = 1; s < SEGS; s++)
            for (int p = 0; p < IW; p++) begin
                m_pv[s][p] = npv[s][p];
                m_pt[s][p] = npt[s][p];
            end
        m_r0 = m_r0 | (m_v & s0);
        m_r1 = m_r1 | (m_v & s1);
        nv = m_v;
        if (free_en) nv[free_idx] = 1'b0;
        if (alloc_en) begin
            nv[alloc_idx]   = 1'b1;
            m_r0[alloc_idx] = alloc_rdy0;
            m_r1[alloc_idx] = alloc_rdy1;
            m_t0[alloc_idx] = int'(alloc_tag0);
            m_t1[alloc_idx] = int'(alloc_tag1);
        end
        m_v   = nv;
        m_bc  = m_bc + nb;
        m_cmp = m_cmp + nb * 2 * SEG_SZ;
    endtask

    task automatic tick();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        alloc_en = 1'b0; free_en = 1'b0;
        done_vld = '0; done_civ = '0; done_fc = '0; done_hr = '0;
        check(rdy0 == m_r0 && rdy1 == m_r1, "R6 model ready flags", {rdy1, rdy0}, {m_r1, m_r0});
        check(req == (m_v & m_r0 & m_r1), "R4 model request", req, m_v & m_r0 & m_r1);
        check(bcast_cnt == CNT_W'(m_bc), "R11 model broadcast count", bcast_cnt, m_bc);
        check(cmp_cnt == CNT_W'(m_cmp), "R11 model compare count", cmp_cnt, m_cmp);
    endtask

    task automatic do_alloc(input int idx, input int t0, input int t1, input bit r0, input bit r1);
        alloc_en = 1'b1; alloc_idx = IDX_W'(idx);
        alloc_tag0 = TAG_W'(t0); alloc_tag1 = TAG_W'(t1);
        alloc_rdy0 = r0; alloc_rdy1 = r1;
    endtask

    task automatic do_done(input int p, input int tag, input bit civ, input bit op,
                           input int idx, input bit fc, input bit hr);
        done_vld[p] = 1'b1;
        done_tag[p*TAG_W +: TAG_W] = TAG_W'(tag);
        done_civ[p] = civ;
        done_cii[p*CII_W +: CII_W] = {op, IDX_W'(idx)};
        done_fc[p] = fc;
        done_hr[p] = hr;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        longint b0, c0;
        void'($urandom(32'd1234));
        for (int e = 0; e < N; e++) begin m_t0[e] = 0; m_t1[e] = 0; end
        for (int s = 0; s < SEGS; s++)
            for (int p = 0; p < IW; p++) begin m_pv[s][p] = 0; m_pt[s][p] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(rdy0 == '0 && rdy1 == '0, "R1 flags after reset", {rdy1, rdy0}, 0);
        check(req == '0, "R1 request after reset", req, 0);
        check(bcast_cnt == '0 && cmp_cnt == '0, "R1 counters after reset", bcast_cnt + cmp_cnt, 0);

        // R2 allocation beats a same-cycle free
        do_alloc(5, 3, 4, 1'b0, 1'b1);
        free_en = 1'b1; free_idx = IDX_W'(5);
        tick();
        check(rdy1[5] == 1'b1 && rdy0[5] == 1'b0, "R2 initial flags", {rdy1[5], rdy0[5]}, 2'b10);
        do_done(0, 40, 1'b1, 1'b0, 5, 1'b0, 1'b0);
        tick();
        check(req[5] == 1'b1, "R2 entry stayed valid", req[5], 1);

        // R5 / R7 near-only broadcast
        do_alloc(1, 3, 0, 1'b0, 1'b1); tick();
        do_alloc(9, 3, 0, 1'b0, 1'b1); tick();
        b0 = longint'(bcast_cnt); c0 = longint'(cmp_cnt);
        do_done(0, 3, 1'b0, 1'b0, 0, 1'b1, 1'b0);
        tick();
        check(rdy0[1] == 1'b1, "R5 segment 0 woken", rdy0[1], 1);
        check(req[1] == 1'b1, "R4 request raised", req[1], 1);
        repeat (3) tick();
        check(rdy0[9] == 1'b0, "R7 far segment untouched", rdy0[9], 0);
        check(longint'(bcast_cnt) - b0 == 1, "R11 one broadcast", longint'(bcast_cnt) - b0, 1);
        check(longint'(cmp_cnt) - c0 == 2 * SEG_SZ, "R11 compares", longint'(cmp_cnt) - c0, 2 * SEG_SZ);

        // R6 far broadcast reaches segment 2 two cycles later
        b0 = longint'(bcast_cnt);
        do_done(1, 3, 1'b0, 1'b0, 0, 1'b0, 1'b1);
        tick();
        check(rdy0[9] == 1'b0, "R6 not yet at edge 0", rdy0[9], 0);
        tick();
        check(rdy0[9] == 1'b0, "R6 not yet at edge 1", rdy0[9], 0);
        tick();
        check(rdy0[9] == 1'b1, "R6 woken at edge 2", rdy0[9], 1);
        tick();
        check(longint'(bcast_cnt) - b0 == SEGS, "R11 full sweep", longint'(bcast_cnt) - b0, SEGS);

        // R9 / R8 pointer wakeup with no hints
        do_alloc(14, 0, 5, 1'b1, 1'b0); tick();
        b0 = longint'(bcast_cnt);
        do_done(0, 9, 1'b1, 1'b1, 14, 1'b0, 1'b0);
        tick();
        check(rdy1[14] == 1'b1 && req[14] == 1'b1, "R9 pointer sets operand 1", {rdy1[14], req[14]}, 2'b11);
        check(longint'(bcast_cnt) == b0, "R8 no broadcast", longint'(bcast_cnt), b0);

        // R3 freed entry ignores wakeups
        do_alloc(2, 6, 6, 1'b0, 1'b0); tick();
        free_en = 1'b1; free_idx = IDX_W'(2); tick();
        do_done(0, 6, 1'b1, 1'b0, 2, 1'b1, 1'b1); tick();
        check(rdy0[2] == 1'b0 && rdy1[2] == 1'b0, "R3 freed entry unchanged", {rdy1[2], rdy0[2]}, 0);
        check(req[2] == 1'b0, "R3 no request after free", req[2], 0);

        // R10 two ports in one cycle
        do_alloc(12, 10, 11, 1'b0, 1'b0); tick();
        do_done(0, 10, 1'b0, 1'b0, 0, 1'b0, 1'b1);
        do_done(1, 11, 1'b0, 1'b0, 0, 1'b0, 1'b1);
        repeat (3) tick();
        check(rdy0[12] == 1'b0, "R10 not before segment 3 edge", rdy0[12], 0);
        tick();
        check(rdy0[12] == 1'b1 && rdy1[12] == 1'b1, "R10 both ports delivered", {rdy1[12], rdy0[12]}, 2'b11);

        // Random traffic against the model
        for (int cyc = 0; cyc < 3000; cyc++) begin
            if ($urandom % 3 == 0)
                do_alloc(int'($urandom % N), int'($urandom % 8), int'($urandom % 8),
                         ($urandom % 4) == 0, ($urandom % 4) == 0);
            if ($urandom % 4 == 0) begin
                free_en = 1'b1; free_idx = IDX_W'($urandom % N);
            end
            for (int p = 0; p < IW; p++)
                if ($urandom % 2 == 0)
                    do_done(p, int'($urandom % 8), ($urandom % 2) == 0, ($urandom % 2) == 0,
                            int'($urandom % N), ($urandom % 2) == 0, ($urandom % 4) == 0);
            tick();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule